// File: doc/BRIEF.md
# LCD Column Scan and Drive-Level Encoder

This block turns stored display lines into per-column drive selections for a dot-matrix LCD. It keeps a 6-bit line pointer. The pointer is loaded with a programmable start line when a frame pulse arrives. It moves forward by one line, modulo 64, on every line clock. For each line clock the block fetches one 80-bit row from the external display memory through a single read port. The memory returns the row one clock after the request. The block then holds the row in 80 column latches.

Each latched bit is combined with the frame-inversion signal and a display-enable bit. The result is a 2-bit code that selects one of four analog drive levels. The frame pulse and the line clock arrive asynchronously. They are synchronised into the system clock and acted on only at their rising edges. Because the scan starts at a programmable line and wraps, the image can be scrolled vertically without moving any stored data.

Top module: `lcd_col_scan`

## Requirements
- R1: After reset the line pointer is 0 and every column latch holds 0, so each column shows the non-select code for the current M ({M,1}). No read is requested until a line clock edge arrives.
- R2: A rising edge of the frame pulse loads the line pointer with `start_line` without requesting a read. The next line clock then reads that line.
- R3: Each rising edge of the line clock produces exactly one single-cycle read request. Its address equals the line pointer, and the pointer then moves to the next line modulo 64, so line 63 is followed by line 0.
- R4: The row returned on `ram_rd_data` one clock after the request is loaded into the column latches on the following clock edge. It is held there until the next line clock read.
- R5: Column i uses bit i of the row, where 1 means pixel on. Its code sits at `seg_code[2i+1:2i]` with the encoding 00 = select with M=0, 01 = non-select with M=0, 10 = select with M=1, 11 = non-select with M=1. The code follows M without waiting for a new line clock.
- R6: While `disp_on` is 0, every column shows the non-select code for the current M. The latched row is kept, and it reappears unchanged once `disp_on` returns to 1.
- R7: When the frame-pulse and line-clock edges fall in the same synchronised cycle, the read uses `start_line` and the pointer becomes `start_line`+1 modulo 64.
- R8: A line clock held high for many cycles causes only one read. Requests are detected only at rising edges, after a two-stage synchroniser.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cl_in | input | 1 | Asynchronous line clock |
| pm_in | input | 1 | Asynchronous frame pulse |
| start_line | input | 6 | Programmed first line of the screen |
| disp_on | input | 1 | Display enable; 0 forces non-select codes |
| m_in | input | 1 | Frame-inversion signal |
| ram_rd_en | output | 1 | One-cycle read request to the display memory |
| ram_rd_addr | output | 6 | Line address of the read |
| ram_rd_data | input | 80 | Row returned one clock after the request |
| seg_code | output | 160 | 2-bit drive-level code per column |

## Verification
The hardest situation to reach from the ports is a frame-pulse edge and a line-clock edge that land in the same synchronised cycle. The bench reaches it by driving both asynchronous inputs on the same falling clock edge, so they pass through identical synchronisers together. The scan wrap is reached by programming start line 62 and issuing three line clocks. A line clock held high for twenty cycles shows that a level alone triggers no extra reads. A row latched while the display is off shows that its data survives the blanking.

// File: rtl/lcd_scan_pkg.sv
`timescale 1ns/1ps
package lcd_scan_pkg;

  typedef enum logic [1:0] {
    LVL_SEL_POS  = 2'b00,
    LVL_NSEL_POS = 2'b01,
    LVL_SEL_NEG  = 2'b10,
    LVL_NSEL_NEG = 2'b11
  } drv_lvl_e;

  // Bit 1 follows inversion, bit 0 is set for non-select.
  function automatic drv_lvl_e enc_level(input logic px, input logic m, input logic on);
    return drv_lvl_e'({m, ~(px & on)});
  endfunction

endpackage

// File: rtl/lcd_edge_sync.sv
`timescale 1ns/1ps
module lcd_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic [STAGES:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg <= '0;
    else        shreg <= {shreg[STAGES-1:0], async_in};
  end

  assign rise = shreg[STAGES-1] & ~shreg[STAGES];

  // R8
  rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);

endmodule

// File: rtl/lcd_line_ctr.sv
`timescale 1ns/1ps
module lcd_line_ctr #(
  parameter int LINE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pm_rise,
  input  logic              cl_rise,
  input  logic [LINE_W-1:0] start_line,
  output logic [LINE_W-1:0] rd_line
);
  localparam logic [LINE_W-1:0] LAST_LINE = '1;

  logic [LINE_W-1:0] cnt;

  function automatic logic [LINE_W-1:0] next_line(input logic [LINE_W-1:0] cur);
    return (cur == LAST_LINE) ? '0 : cur + 1'b1;
  endfunction

  assign rd_line = pm_rise ? start_line : cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (cl_rise) cnt <= next_line(rd_line);
    else if (pm_rise) cnt <= start_line;
  end

  // R2
  pm_preset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_rise && !cl_rise) |=> (cnt == $past(start_line)));
  // R3
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cl_rise && !pm_rise && cnt == LAST_LINE) |=> (cnt == '0));
  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cl_rise && !pm_rise) |=> $stable(cnt));
  // R7
  both_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cl_rise && pm_rise) |=> (cnt == LINE_W'($past(start_line) + 1'b1)));

endmodule

// File: rtl/lcd_col_latch.sv
`timescale 1ns/1ps
module lcd_col_latch #(
  parameter int NUM_COLS = 80
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [NUM_COLS-1:0] din,
  output logic [NUM_COLS-1:0] dout
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    dout <= '0;
    else if (load) dout <= din;
  end

  // R4
  latch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (dout == $past(din)));
  // R4
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(dout));

endmodule

// File: rtl/lcd_level_enc.sv
`timescale 1ns/1ps
module lcd_level_enc
  import lcd_scan_pkg::*;
#(
  parameter int NUM_COLS = 80
) (
  input  logic [NUM_COLS-1:0]   pix,
  input  logic                  m,
  input  logic                  disp_on,
  output logic [2*NUM_COLS-1:0] codes
);
  for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
    drv_lvl_e lvl;
    assign lvl = enc_level(pix[c], m, disp_on);
    assign codes[2*c +: 2] = lvl;
  end

endmodule

// File: rtl/lcd_col_scan.sv
`timescale 1ns/1ps
module lcd_col_scan #(
  parameter int NUM_COLS    = 80,
  parameter int LINE_W      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cl_in,
  input  logic                  pm_in,
  input  logic [LINE_W-1:0]     start_line,
  input  logic                  disp_on,
  input  logic                  m_in,
  output logic                  ram_rd_en,
  output logic [LINE_W-1:0]     ram_rd_addr,
  input  logic [NUM_COLS-1:0]   ram_rd_data,
  output logic [2*NUM_COLS-1:0] seg_code
);
  localparam int CODE_W = 2 * NUM_COLS;

  logic                cl_rise;
  logic                pm_rise;
  logic                rd_pend;
  logic [NUM_COLS-1:0] col_bits;
  logic [CODE_W-1:0]   nsel_mask;

  lcd_edge_sync #(.STAGES(SYNC_STAGES)) u_cl_sync (
    .clk(clk), .rst_n(rst_n), .async_in(cl_in), .rise(cl_rise));

  lcd_edge_sync #(.STAGES(SYNC_STAGES)) u_pm_sync (
    .clk(clk), .rst_n(rst_n), .async_in(pm_in), .rise(pm_rise));

  lcd_line_ctr #(.LINE_W(LINE_W)) u_line (
    .clk(clk), .rst_n(rst_n), .pm_rise(pm_rise), .cl_rise(cl_rise),
    .start_line(start_line), .rd_line(ram_rd_addr));

  assign ram_rd_en = cl_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_pend <= 1'b0;
    else        rd_pend <= cl_rise;
  end

  lcd_col_latch #(.NUM_COLS(NUM_COLS)) u_latch (
    .clk(clk), .rst_n(rst_n), .load(rd_pend), .din(ram_rd_data), .dout(col_bits));

  lcd_level_enc #(.NUM_COLS(NUM_COLS)) u_enc (
    .pix(col_bits), .m(m_in), .disp_on(disp_on), .codes(seg_code));

  for (genvar k = 0; k < NUM_COLS; k++) begin : g_mask
    assign nsel_mask[2*k +: 2] = 2'b01;
  end

  // R3
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_rd_en |=> !ram_rd_en);
  // R6
  blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_on |-> ((seg_code & nsel_mask) == nsel_mask));
  // R5
  inv_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seg_code[1] == m_in);

endmodule

// File: tb/lcd_col_scan_bench.sv
`timescale 1ns/1ps
module lcd_col_scan_bench;
  localparam int NC = 80;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cl_in = 1'b0;
  logic          pm_in = 1'b0;
  logic [5:0]    start_line = '0;
  logic          disp_on = 1'b1;
  logic          m_in = 1'b0;
  logic          ram_rd_en;
  logic [5:0]    ram_rd_addr;
  logic [NC-1:0] ram_q = '0;
  logic [2*NC-1:0] seg_code;

  int n_cmp = 0;
  int n_bad = 0;
  int exp_q[$];
  int last_addr = 0;
  bit done = 0;

  always #5 clk = ~clk;

  lcd_col_scan u_lcd_col_scan (
    .clk(clk), .rst_n(rst_n), .cl_in(cl_in), .pm_in(pm_in),
    .start_line(start_line), .disp_on(disp_on), .m_in(m_in),
    .ram_rd_en(ram_rd_en), .ram_rd_addr(ram_rd_addr),
    .ram_rd_data(ram_q), .seg_code(seg_code));

  function automatic logic [NC-1:0] row_pat(input int a);
    logic [NC-1:0] r;
    for (int i = 0; i < NC; i++)
      r[i] = ((((i * 3) + (a * 5)) % 7) < 3) ^ (i == a);
    return r;
  endfunction

  function automatic logic [2*NC-1:0] exp_seg(input logic [NC-1:0] r, input logic m, input logic on);
    logic [2*NC-1:0] s;
    for (int i = 0; i < NC; i++) begin
      if (on && r[i]) s[2*i +: 2] = m ? 2'b10 : 2'b00;
      else            s[2*i +: 2] = m ? 2'b11 : 2'b01;
    end
    return s;
  endfunction

  // memory model: one clock read latency
  always @(posedge clk) if (ram_rd_en) ram_q <= row_pat(int'(ram_rd_addr));

  task automatic chk(input bit ok, input string req, input logic [2*NC-1:0] act, input logic [2*NC-1:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  // driver: pushes the line expected for each clock pulse
  task automatic cl_pulse(input int exp_line, input int hold);
    exp_q.push_back(exp_line);
    cl_in = 1'b1; ticks(hold); cl_in = 1'b0; ticks(6);
  endtask

  task automatic pm_pulse();
    pm_in = 1'b1; ticks(3); pm_in = 1'b0; ticks(4);
  endtask

  // monitor: pops expected lines and compares address and codes
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && ram_rd_en) begin
        int a;
        if (exp_q.size() == 0) begin
          chk(0, "R3/R8 unexpected read", 160'(ram_rd_addr), 160'(0));
        end else begin
          a = exp_q.pop_front();
          chk(ram_rd_addr == 6'(a), "R3 read address", 160'(ram_rd_addr), 160'(a));
          ticks(2);
          last_addr = a;
          chk(seg_code == exp_seg(row_pat(a), m_in, disp_on), "R4/R5 latched codes",
              seg_code, exp_seg(row_pat(a), m_in, disp_on));
        end
      end
    end
  end

  initial begin
    ticks(200000);
    chk(0, "watchdog expired", '0, '0);
    finish_run();
  end

  initial begin
    ticks(4);
    rst_n = 1'b1;
    ticks(4);
    // R1 reset state
    chk(seg_code == exp_seg('0, 1'b0, 1'b1), "R1 reset codes", seg_code, exp_seg('0, 1'b0, 1'b1));
    chk(ram_rd_en == 1'b0, "R1 no read after reset", 160'(ram_rd_en), '0);
    // R1 first line clock reads line 0
    cl_pulse(0, 3);

    // R2 preset, then scan forward
    start_line = 6'd5;
    pm_pulse();
    chk(seg_code == exp_seg(row_pat(0), 1'b0, 1'b1), "R2 preset leaves latches", seg_code, exp_seg(row_pat(0), 1'b0, 1'b1));
    cl_pulse(5, 3);
    cl_pulse(6, 3);
    cl_pulse(7, 3);

    // R5 inversion follows M without a line clock
    m_in = 1'b1; ticks(1);
    chk(seg_code == exp_seg(row_pat(7), 1'b1, 1'b1), "R5 inverted codes", seg_code, exp_seg(row_pat(7), 1'b1, 1'b1));

    // R6 blanking and restore
    disp_on = 1'b0; ticks(1);
    chk(seg_code == exp_seg(row_pat(7), 1'b1, 1'b0), "R6 blanked", seg_code, exp_seg(row_pat(7), 1'b1, 1'b0));
    disp_on = 1'b1; ticks(1);
    chk(seg_code == exp_seg(row_pat(7), 1'b1, 1'b1), "R6 restored", seg_code, exp_seg(row_pat(7), 1'b1, 1'b1));

    // R8 held line clock gives one read
    m_in = 1'b0;
    cl_pulse(8, 20);
    chk(exp_q.size() == 0, "R8 single read for held level", 160'(exp_q.size()), '0);
    cl_pulse(9, 2);

    // R3 wrap from 63 to 0
    start_line = 6'd62;
    pm_pulse();
    cl_pulse(62, 3);
    cl_pulse(63, 3);
    cl_pulse(0, 3);
    cl_pulse(1, 3);

    // R7 frame and line edges together
    start_line = 6'd20;
    exp_q.push_back(20);
    pm_in = 1'b1; cl_in = 1'b1; ticks(3);
    pm_in = 1'b0; cl_in = 1'b0; ticks(6);
    cl_pulse(21, 3);

    // R6 row latched while blanked survives
    disp_on = 1'b0; m_in = 1'b1;
    cl_pulse(22, 3);
    chk(seg_code == exp_seg(row_pat(22), 1'b1, 1'b0), "R6 blank during load", seg_code, exp_seg(row_pat(22), 1'b1, 1'b0));
    disp_on = 1'b1; ticks(1);
    chk(seg_code == exp_seg(row_pat(22), 1'b1, 1'b1), "R6 data kept through blank", seg_code, exp_seg(row_pat(22), 1'b1, 1'b1));

    ticks(5);
    chk(exp_q.size() == 0, "R3 all expected reads seen", 160'(exp_q.size()), '0);
    finish_run();
  end

endmodule